// File: doc/BRIEF.md
# External Interrupt Polarity Converter

This block sits between two external interrupt pins and a parent interrupt controller that understands only active-high levels and rising edges. Each pin is asynchronous to the block clock. The block synchronizes each pin and detects the trigger type chosen for that channel: high level, low level, rising edge or falling edge. It then drives one output line per channel that is always either an active-high level or a single-cycle high pulse. Software can therefore accept any pin sense while the parent keeps its own simple configuration.

Each channel has a configuration word on a 32-bit register bus. The word holds an enable, a level/edge select and a polarity bit. A channel whose enable is clear stays silent. The words read back exactly the writable bits, so software can save both words before a power transition and write them back afterwards. The word at offset zero is a global slot that reads as zero. Changing a channel's trigger type re-arms its edge detector, so reconfiguring a channel cannot fire a false pulse.

Top module: `irq_sense_norm`

## Requirements
- R1: While reset is asserted, both configuration words clear to zero and both outputs drive low, and they stay so after reset releases until software writes a configuration.
- R2: The configuration word of channel n sits at byte offset 4 + 4·n (address bits [1:0] ignored). Only bit 16 (enable), bit 9 (level select) and bit 8 (polarity) are stored, and all other bits read as zero.
- R3: Offset 0x0 and every offset that maps to no channel read as zero. Writes there change neither configuration word.
- R4: With the enable bit clear, the channel output stays low whatever the pin does, in every trigger mode.
- R5: Level select 1 with polarity 1 (active-high level): the output is high while the pin is high. A pin change shows on the output after the third rising clock edge that follows it.
- R6: Level select 1 with polarity 0 (active-low level): the output is high while the pin is low, with the same three-edge latency.
- R7: Level select 0 with polarity 0 (rising edge): each rising edge of the pin gives a high pulse exactly one clock wide, three edges later. Falling edges and a steady pin give nothing.
- R8: Level select 0 with polarity 1 (falling edge): each falling edge of the pin gives a one-clock high pulse, and rising edges give nothing.
- R9: A write that changes a channel's level/polarity bits clears its edge history, so no pulse results from the reconfiguration alone. The next real edge is still detected.
- R10: The two channels are independent. The pin and configuration of one never affect the other's output.
- R11: Writing zero to a configuration word disables the channel and clears its type. Writing a previously read-back value restores the original behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected address (combinational) |
| pin_in | input | 2 | Asynchronous external interrupt pins, one per channel |
| irq_out | output | 2 | Normalized interrupt lines toward the parent, one per channel |

## Verification
The bench targets the mode switch that inverts the edge sense while the pin sits still. A design that forgets to re-arm the detector would raise a pulse right after the write. It checks that each edge mode ignores the opposite edge: a wrong decode would pulse on both edges or on the wrong one. It measures the exact cycle and width of each pulse and level change, which exposes a missing or extra synchronizer stage or a stretched pulse. It also writes all ones and then zero and reads back, so that a design storing unused bits or failing to clear its type fails the check. A design that lets the global slot alias a channel also fails.

// File: rtl/irqn_pkg.sv
// Package: shared constants and types of the interrupt polarity converter.
// Assumes a 32-bit register bus with word-aligned channel slots.
package irqn_pkg;

    localparam int BUS_W   = 32;
    localparam int EN_BIT  = 16;
    localparam int LVL_BIT = 9;
    localparam int POL_BIT = 8;

    // Stored fields of one channel configuration word
    typedef struct packed {
        logic en;
        logic lvl;
        logic pol;
    } chan_cfg_t;

    // Build the bus image of a configuration; unstored bits are zero
    function automatic logic [BUS_W-1:0] cfg_to_word(chan_cfg_t c);
        logic [BUS_W-1:0] w;
        w          = '0;
        w[EN_BIT]  = c.en;
        w[LVL_BIT] = c.lvl;
        w[POL_BIT] = c.pol;
        return w;
    endfunction

    // Extract the stored fields from a bus word
    function automatic chan_cfg_t word_to_cfg(logic [BUS_W-1:0] w);
        chan_cfg_t c;
        c.en  = w[EN_BIT];
        c.lvl = w[LVL_BIT];
        c.pol = w[POL_BIT];
        return c;
    endfunction

endpackage

// File: rtl/irqn_sync.sv
// Module: two-stage synchronizer for a vector of asynchronous pins.
// Assumes each bit is an independent quasi-static signal; no bus coherency.
module irqn_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;

    // Capture the pins, then re-register to settle metastability
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_i;
            stable_q <= meta_q;
        end
    end

    assign sync_o = stable_q;

endmodule

// File: rtl/irqn_regs.sv
// Module: configuration word bank on the register bus.
// Slot 0 is a read-as-zero global word; channel n lives at word index n+1.
// Assumes single-cycle writes qualified by bus_sel and bus_wr.
module irqn_regs
    import irqn_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [BUS_W-1:0]      bus_wdata,
    output logic [BUS_W-1:0]      bus_rdata,
    output chan_cfg_t [NCH-1:0]   cfg_o,
    output logic [NCH-1:0]        type_chg_o
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] widx;
    chan_cfg_t        wr_cfg;
    logic             unused_bits;

    assign widx        = bus_addr[ADDR_W-1:2];
    assign wr_cfg      = word_to_cfg(bus_wdata);
    assign unused_bits = ^{bus_addr[1:0], bus_wdata};

    generate
        for (genvar n = 0; n < NCH; n++) begin : g_slot
            logic      hit;
            chan_cfg_t cfg_q;

            assign hit = bus_sel && bus_wr && (widx == IDX_W'(n + 1));

            // Hold the channel configuration, loaded by a matching write
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cfg_q <= '0;
                end else if (hit) begin
                    cfg_q <= wr_cfg;
                end
            end

            assign cfg_o[n]      = cfg_q;
            assign type_chg_o[n] = hit &&
                ({wr_cfg.lvl, wr_cfg.pol} != {cfg_q.lvl, cfg_q.pol});
        end
    endgenerate

    // Return the addressed channel word, zero for the global or unmapped slots
    always_comb begin
        bus_rdata = '0;
        for (int n = 0; n < NCH; n++) begin
            if (bus_sel && (widx == IDX_W'(n + 1))) begin
                bus_rdata = cfg_to_word(cfg_o[n]);
            end
        end
    end

endmodule

// File: rtl/irqn_chan.sv
// Module: sense logic of one channel.
// Turns a synchronized pin into an active-high level or a one-cycle pulse.
// Assumes sync_i is already in the clk domain; type_chg_i pulses on the
// same edge that loads a new type into cfg_i.
module irqn_chan
    import irqn_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  chan_cfg_t cfg_i,
    input  logic      type_chg_i,
    input  logic      sync_i,
    output logic      irq_o
);

    logic edge_x;
    logic level_x;
    logic prev_q;
    logic armed_q;
    logic irq_q;

    // Normalize the pin so the selected sense becomes active-high
    assign edge_x  = cfg_i.pol ? ~sync_i : sync_i;
    assign level_x = cfg_i.pol ?  sync_i : ~sync_i;

    // Track edge history, re-arm after a type change, register the output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            armed_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            prev_q  <= edge_x;
            armed_q <= ~type_chg_i;
            if (!cfg_i.en) begin
                irq_q <= 1'b0;
            end else if (cfg_i.lvl) begin
                irq_q <= level_x;
            end else begin
                irq_q <= armed_q & edge_x & ~prev_q;
            end
        end
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/irq_sense_norm.sv
// Module: top of the external interrupt polarity converter.
// Synchronizes NCH pins, applies each channel's configured sense and
// drives parent-compatible active-high levels or rising pulses.
// Assumes the parent samples irq_out in the clk domain.
module irq_sense_norm
    import irqn_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NCH-1:0]    pin_in,
    output logic [NCH-1:0]    irq_out
);

    chan_cfg_t [NCH-1:0] cfg_w;
    logic [NCH-1:0]      type_chg_w;
    logic [NCH-1:0]      sync_w;

    irqn_regs #(
        .NCH    (NCH),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cfg_o      (cfg_w),
        .type_chg_o (type_chg_w)
    );

    irqn_sync #(
        .W (NCH)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (sync_w)
    );

    generate
        for (genvar n = 0; n < NCH; n++) begin : g_chan
            irqn_chan u_chan (
                .clk        (clk),
                .rst_n      (rst_n),
                .cfg_i      (cfg_w[n]),
                .type_chg_i (type_chg_w[n]),
                .sync_i     (sync_w[n]),
                .irq_o      (irq_out[n])
            );
        end
    endgenerate

endmodule

// File: rtl/irq_sense_norm_chk.sv
// Module: assertion checker bound to irq_sense_norm.
// Observes the bus, the stored configuration and the outputs.
module irq_sense_norm_chk
    import irqn_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_sel,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [31:0]         bus_wdata,
    input logic [31:0]         bus_rdata,
    input chan_cfg_t [NCH-1:0] cfg,
    input logic [NCH-1:0]      irq_out
);

    localparam int IDX_W = ADDR_W - 2;

    // R1: reset clears configuration and outputs
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (irq_out == '0 && cfg == '0));

    // R3: global slot reads zero
    p_global_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr[ADDR_W-1:2] == '0) |-> bus_rdata == '0);

    generate
        for (genvar n = 0; n < NCH; n++) begin : g_chk
            // R2: a channel write stores exactly the three field bits
            p_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_sel && bus_wr && bus_addr[ADDR_W-1:2] == IDX_W'(n + 1))
                |=> cfg[n] == {$past(bus_wdata[EN_BIT]),
                               $past(bus_wdata[LVL_BIT]),
                               $past(bus_wdata[POL_BIT])});

            // R4: a disabled channel stays silent on the next cycle
            p_quiet_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
                !cfg[n].en |=> !irq_out[n]);

            // R7: edge pulses are one cycle wide
            p_pulse_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (!cfg[n].lvl && $stable(cfg[n]) && irq_out[n]) |=> !irq_out[n]);
        end
    endgenerate

endmodule

bind irq_sense_norm irq_sense_norm_chk #(
    .NCH    (NCH),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg       (cfg_w),
    .irq_out   (irq_out)
);

// File: tb/sim_irq_sense_norm.sv
module sim_irq_sense_norm;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  pin_in = '0;
    logic [1:0]  irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [31:0] C_EN   = 32'h0001_0000;
    localparam logic [31:0] C_LVL  = 32'h0000_0200;
    localparam logic [31:0] C_POL  = 32'h0000_0100;

    always #10 clk = ~clk;

    irq_sense_norm u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .irq_out   (irq_out)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // Expect a quiet output on channel ch for n cycles
    task automatic quiet(string req, int ch, int n);
        for (int i = 0; i < n; i++) begin
            step(1);
            chk(req, 32'(irq_out[ch]), 32'd0);
        end
    endtask

    // Expect a single-cycle pulse three edges after the pin was driven
    task automatic expect_pulse(string req, int ch);
        step(2); chk(req, 32'(irq_out[ch]), 32'd0);
        step(1); chk(req, 32'(irq_out[ch]), 32'd1);
        step(1); chk(req, 32'(irq_out[ch]), 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq", 32'(irq_out), 32'd0);
        rd(8'h04, d); chk("R1 cfg0", d, 32'd0);
        rd(8'h08, d); chk("R1 cfg1", d, 32'd0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, d); chk("R2 mask ch0", d, 32'h0001_0300);
        wr(8'h0B, C_EN | C_POL);
        rd(8'h08, d); chk("R2 ch1 offset", d, 32'h0001_0100);
        rd(8'h04, d); chk("R10 ch0 kept", d, 32'h0001_0300);
        wr(8'h04, 32'd0);
        wr(8'h08, 32'd0);
    endtask

    task automatic t_global();
        logic [31:0] d;
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h00, d); chk("R3 global", d, 32'd0);
        rd(8'h0C, d); chk("R3 unmapped", d, 32'd0);
        rd(8'h04, d); chk("R3 ch0 untouched", d, 32'd0);
        rd(8'h08, d); chk("R3 ch1 untouched", d, 32'd0);
    endtask

    task automatic t_disabled();
        wr(8'h04, C_LVL | C_POL);
        pin_in[0] = 1'b1;
        quiet("R4 level off", 0, 5);
        wr(8'h04, 32'd0);
        pin_in[0] = 1'b0;
        quiet("R4 edge off", 0, 5);
        pin_in[0] = 1'b1;
        quiet("R4 edge off", 0, 5);
        pin_in[0] = 1'b0;
        step(4);
    endtask

    task automatic t_level_high();
        wr(8'h04, C_EN | C_LVL | C_POL);
        step(2); chk("R5 low pin", 32'(irq_out[0]), 32'd0);
        pin_in[0] = 1'b1;
        step(2); chk("R5 latency", 32'(irq_out[0]), 32'd0);
        step(1); chk("R5 asserted", 32'(irq_out[0]), 32'd1);
        step(3); chk("R5 held", 32'(irq_out[0]), 32'd1);
        pin_in[0] = 1'b0;
        step(2); chk("R5 still high", 32'(irq_out[0]), 32'd1);
        step(1); chk("R5 released", 32'(irq_out[0]), 32'd0);
        wr(8'h04, 32'd0);
        step(2);
    endtask

    task automatic t_level_low();
        pin_in[1] = 1'b1;
        step(4);
        wr(8'h08, C_EN | C_LVL);
        step(2); chk("R6 high pin", 32'(irq_out[1]), 32'd0);
        pin_in[1] = 1'b0;
        step(2); chk("R6 latency", 32'(irq_out[1]), 32'd0);
        step(1); chk("R6 asserted", 32'(irq_out[1]), 32'd1);
        chk("R10 ch0 quiet", 32'(irq_out[0]), 32'd0);
        pin_in[1] = 1'b1;
        step(3); chk("R6 released", 32'(irq_out[1]), 32'd0);
        wr(8'h08, 32'd0);
        pin_in[1] = 1'b0;
        step(4);
    endtask

    task automatic t_rising();
        wr(8'h04, C_EN);
        step(3);
        pin_in[0] = 1'b1;
        expect_pulse("R7 rise", 0);
        quiet("R7 steady high", 0, 3);
        pin_in[0] = 1'b0;
        quiet("R7 fall ignored", 0, 5);
        pin_in[0] = 1'b1;
        expect_pulse("R7 second rise", 0);
        pin_in[0] = 1'b0;
        step(4);
    endtask

    task automatic t_falling();
        pin_in[0] = 1'b1;
        step(4);
        wr(8'h04, C_EN | C_POL);
        step(3);
        pin_in[0] = 1'b0;
        expect_pulse("R8 fall", 0);
        pin_in[0] = 1'b1;
        quiet("R8 rise ignored", 0, 5);
        pin_in[0] = 1'b0;
        expect_pulse("R8 second fall", 0);
        step(2);
    endtask

    task automatic t_retype();
        wr(8'h04, C_EN);
        step(4);
        wr(8'h04, C_EN | C_POL);
        chk("R9 at write", 32'(irq_out[0]), 32'd0);
        quiet("R9 no spurious", 0, 5);
        pin_in[0] = 1'b1;
        quiet("R9 rise ignored", 0, 5);
        wr(8'h04, C_EN);
        quiet("R9 no spurious back", 0, 5);
        pin_in[0] = 1'b0;
        quiet("R9 fall ignored", 0, 5);
        pin_in[0] = 1'b1;
        expect_pulse("R9 edge after retype", 0);
        pin_in[0] = 1'b0;
        step(4);
    endtask

    task automatic t_indep();
        wr(8'h08, C_EN | C_LVL | C_POL);
        pin_in[1] = 1'b1;
        step(2);
        chk("R10 ch0 unaffected", 32'(irq_out[0]), 32'd0);
        step(1);
        chk("R10 ch1 level", 32'(irq_out[1]), 32'd1);
        pin_in[0] = 1'b1;
        step(3);
        chk("R10 ch0 pulse", 32'(irq_out[0]), 32'd1);
        chk("R10 ch1 held", 32'(irq_out[1]), 32'd1);
        pin_in[0] = 1'b0;
        pin_in[1] = 1'b0;
        step(4);
    endtask

    task automatic t_save_restore();
        logic [31:0] s0, s1, d;
        wr(8'h08, C_EN | C_LVL);
        step(3);
        chk("R11 active before", 32'(irq_out[1]), 32'd1);
        rd(8'h04, s0);
        rd(8'h08, s1);
        wr(8'h04, 32'd0);
        wr(8'h08, 32'd0);
        rd(8'h08, d); chk("R11 cleared", d, 32'd0);
        step(1); chk("R11 disabled", 32'(irq_out[1]), 32'd0);
        wr(8'h04, s0);
        wr(8'h08, s1);
        rd(8'h08, d); chk("R11 restored", d, 32'h0001_0200);
        step(1); chk("R11 active again", 32'(irq_out[1]), 32'd1);
        pin_in[0] = 1'b1;
        expect_pulse("R11 ch0 edge restored", 0);
    endtask

    initial begin
        step(3);
        chk("R1 irq in reset", 32'(irq_out), 32'd0);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_regs();
        t_global();
        t_disabled();
        t_level_high();
        t_level_low();
        t_rising();
        t_falling();
        t_retype();
        t_indep();
        t_save_restore();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule